// File: doc/BRIEF.md
# Video Standard Auto-Detect Monitor

This block watches an on-screen-display overlay device and keeps its output format (PAL or NTSC) consistent with the incoming video. Each millisecond tick that finds the block idle starts a poll. The poll first reads back the device's mode register. If the value read differs from the expected one, the device is taken to have stalled or been reset, and a reinitialisation is requested at once. If the read-back matches and the configuration is automatic, the block reads the device status byte at a bounded rate. A format mismatch has to persist across a debounce window before a reinitialisation is requested. A loss-of-signal indication cancels any pending debounce.

Device access goes through a request/response handshake that stands in for the serial transport. The block raises `rd_valid` with `rd_sel` (0 = mode register, 1 = status byte). It holds both steady until `rd_ready` is seen high on a clock edge. It then waits for a single-cycle `rsp_valid` carrying the byte. The block is always ready for a response while it waits for one, and it ignores `rsp_valid` at any other time. `reinit_pulse` tells the surrounding driver to rewrite the device with `mode_word`, the expected mode register value.

Top module: `vstd_monitor`

## Requirements
- R1: After reset `reinit_pulse` and `rd_valid` are low, `mode_pal` is 0 (NTSC) and `mode_word` is 8'h08.
- R2: An `ms_tick` seen while idle starts a poll whose first request has `rd_sel`=0. `rd_valid` and `rd_sel` stay stable until `rd_ready` is seen. A `rsp_valid` arriving while no response is awaited has no effect.
- R3: The expected mode word has bit 6 = `mode_pal`, bit 3 = 1 and all other bits 0. A read-back that differs from it requests reinitialisation immediately, and that poll makes no periodic status check.
- R4: The status byte is read periodically only when `cfg_mode` is automatic (2'b00 or 2'b11). A check happens when the poll time minus the last check time exceeds CHECK_MS, and the check time is then updated. Forced PAL (2'b01) and forced NTSC (2'b10) never read status except as R9 states.
- R5: Status bit 0 = PAL seen, bit 1 = NTSC seen, bit 2 = loss of signal. Every other bit, including the busy flag in bit 5, has no effect.
- R6: A status check with loss of signal cancels any pending debounce and changes nothing.
- R7: Without loss of signal, the input counts as PAL when bit 0 is set and as NTSC when bit 0 is clear, whatever bit 1 holds. A mismatch is an input format different from `mode_pal`.
- R8: The first mismatching check records the poll time. A later mismatching check requests reinitialisation only if more than DEBOUNCE_MS have passed since that recorded time. A matching check does not cancel the pending debounce.
- R9: On reinitialisation, forced modes select their format directly. Automatic mode reads status once more and selects NTSC if bit 1 is set without loss of signal, else PAL if bit 0 is set without loss of signal, else NTSC.
- R10: `reinit_pulse` lasts one cycle. `mode_pal` and `mode_word` change only in that cycle, and any pending debounce is cancelled.
- R11: Time differences are taken modulo 2^TIME_W, so a wrap of the millisecond counter does not disturb the interval or the debounce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_mode | input | 2 | 00/11 automatic, 01 forced PAL, 10 forced NTSC |
| rd_valid | output | 1 | Device read request valid |
| rd_ready | input | 1 | Transport accepts the request |
| rd_sel | output | 1 | 0 = mode register, 1 = status byte |
| rsp_valid | input | 1 | Response byte valid (one cycle) |
| rsp_data | input | 8 | Response byte |
| reinit_pulse | output | 1 | Reinitialise request, one cycle |
| mode_pal | output | 1 | Selected format, 1 = PAL |
| mode_word | output | 8 | Expected mode register value |

## Verification
The hardest state to reach is a debounce that is armed and then cancelled by loss of signal partway through its window, followed by a fresh mismatch that has to wait a full window again. Reaching it takes a status sequence timed against the check interval. A second hard case is the strict boundary, where exactly DEBOUNCE_MS has elapsed and no reinitialisation may happen yet. The bench builds both cases with small interval and debounce parameters and a narrow time counter, holding each status value for a planned number of ticks, so both the boundary and a counter wrap fall inside the run. Forced-mode stalls are created by corrupting the device register model between ticks.

// File: rtl/vstd_pkg.sv
package vstd_pkg;
  typedef enum logic [1:0] {
    CFG_AUTO     = 2'b00,
    CFG_PAL      = 2'b01,
    CFG_NTSC     = 2'b10,
    CFG_AUTO_ALT = 2'b11
  } cfg_e;

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} phase_e;
  typedef enum logic [1:0] {RD_MODE, RD_STAT, RD_INIT} purp_e;

  localparam int ST_PAL_BIT  = 0;
  localparam int ST_NTSC_BIT = 1;
  localparam int ST_LOS_BIT  = 2;
  localparam int MR_PAL_BIT  = 6;
  localparam int MR_EN_BIT   = 3;

  function automatic logic [7:0] mode_word_f(input logic pal);
    logic [7:0] w;
    w = '0;
    w[MR_EN_BIT]  = 1'b1;
    w[MR_PAL_BIT] = pal;
    return w;
  endfunction
endpackage

// File: rtl/vstd_timebase.sv
module vstd_timebase #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [TIME_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else if (tick) now <= now + 1'b1;
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> now == TIME_W'($past(now) + 1'b1)); // R11
endmodule

// File: rtl/vstd_status_eval.sv
module vstd_status_eval (
  input  logic [2:0] stat,
  input  logic       cur_pal,
  output logic       los,
  output logic       mismatch,
  output logic       init_pal
);
  import vstd_pkg::*;
  logic pal_in, ntsc_loose;

  always_comb begin
    los        = stat[ST_LOS_BIT];
    pal_in     = !los && stat[ST_PAL_BIT];
    ntsc_loose = !los && !stat[ST_PAL_BIT];
    mismatch   = cur_pal ? ntsc_loose : pal_in;
    init_pal   = !los && !stat[ST_NTSC_BIT] && stat[ST_PAL_BIT];
  end
endmodule

// File: rtl/vstd_debounce.sv
module vstd_debounce #(
  parameter int TIME_W      = 32,
  parameter int DEBOUNCE_MS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              los,
  input  logic              mismatch,
  input  logic              clear,
  input  logic [TIME_W-1:0] now,
  output logic              expire
);
  localparam logic [TIME_W-1:0] DB_LIM = TIME_W'(DEBOUNCE_MS);

  logic              armed;
  logic [TIME_W-1:0] stamp;
  logic [TIME_W-1:0] elapsed;

  assign elapsed = now - stamp;
  assign expire  = sample && armed && mismatch && !los && (elapsed > DB_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      stamp <= '0;
    end else if (clear) begin
      armed <= 1'b0;
    end else if (sample) begin
      if (los) armed <= 1'b0;
      else if (mismatch && !armed) begin
        armed <= 1'b1;
        stamp <= now;
      end
    end
  end

  AST_LOS_DROPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    sample && los |=> !armed); // R6
  AST_FIRST_MISMATCH_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    sample && !los && mismatch && !armed && !clear |=> armed && stamp == $past(now)); // R8
  AST_CLEAR_DROPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !armed); // R10
endmodule

// File: rtl/vstd_monitor.sv
module vstd_monitor
  import vstd_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter int CHECK_MS    = 1000,
  parameter int DEBOUNCE_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [1:0] cfg_mode,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic       rd_sel,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  output logic       reinit_pulse,
  output logic       mode_pal,
  output logic [7:0] mode_word
);
  localparam logic [TIME_W-1:0] CHK_LIM = TIME_W'(CHECK_MS);

  phase_e            phase;
  purp_e             purp;
  logic [TIME_W-1:0] now, poll_now, last_chk, since_chk;
  logic              accept, auto_cfg, chk_due, stat_sample;
  logic              los, mismatch, init_pal, expire;
  logic              need_init, go_stat, go_init, fire, fire_pal;

  vstd_timebase #(.TIME_W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .now(now));

  vstd_status_eval u_eval (
    .stat(rsp_data[2:0]), .cur_pal(mode_pal),
    .los(los), .mismatch(mismatch), .init_pal(init_pal));

  vstd_debounce #(.TIME_W(TIME_W), .DEBOUNCE_MS(DEBOUNCE_MS)) u_db (
    .clk(clk), .rst_n(rst_n), .sample(stat_sample), .los(los),
    .mismatch(mismatch), .clear(fire), .now(poll_now), .expire(expire));

  assign rd_valid    = (phase == PH_REQ);
  assign rd_sel      = (purp != RD_MODE);
  assign mode_word   = mode_word_f(mode_pal);
  assign accept      = rsp_valid && (phase == PH_WAIT);
  assign auto_cfg    = (cfg_mode == CFG_AUTO) || (cfg_mode == CFG_AUTO_ALT);
  assign since_chk   = poll_now - last_chk;
  assign chk_due     = since_chk > CHK_LIM;
  assign stat_sample = accept && (purp == RD_STAT);

  always_comb begin
    need_init = 1'b0;
    go_stat   = 1'b0;
    go_init   = 1'b0;
    fire      = 1'b0;
    fire_pal  = mode_pal;
    if (accept) begin
      unique case (purp)
        RD_MODE: begin
          if (rsp_data != mode_word) need_init = 1'b1;
          else if (auto_cfg && chk_due) go_stat = 1'b1;
        end
        RD_STAT: need_init = expire;
        default: begin
          fire     = 1'b1;
          fire_pal = init_pal;
        end
      endcase
    end
    if (need_init) begin
      if (cfg_mode == CFG_PAL) begin
        fire     = 1'b1;
        fire_pal = 1'b1;
      end else if (cfg_mode == CFG_NTSC) begin
        fire     = 1'b1;
        fire_pal = 1'b0;
      end else begin
        go_init = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      purp         <= RD_MODE;
      poll_now     <= '0;
      last_chk     <= '0;
      mode_pal     <= 1'b0;
      reinit_pulse <= 1'b0;
    end else begin
      reinit_pulse <= fire;
      if (fire) mode_pal <= fire_pal;
      unique case (phase)
        PH_IDLE: if (ms_tick) begin
          poll_now <= now;
          purp     <= RD_MODE;
          phase    <= PH_REQ;
        end
        PH_REQ: if (rd_ready) phase <= PH_WAIT;
        default: if (rsp_valid) begin
          if (go_stat) begin
            last_chk <= poll_now;
            purp     <= RD_STAT;
            phase    <= PH_REQ;
          end else if (go_init) begin
            purp  <= RD_INIT;
            phase <= PH_REQ;
          end else begin
            phase <= PH_IDLE;
          end
        end
      endcase
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |=> !reinit_pulse); // R10
  AST_MODE_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pal != $past(mode_pal) |-> reinit_pulse); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_sel)); // R2
  AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && purp == RD_MODE && rsp_data != mode_word |=> reinit_pulse || (rd_valid && purp == RD_INIT)); // R3
endmodule

// File: tb/vstd_monitor_tb_top.sv
module vstd_monitor_tb_top;
  localparam int TW  = 6;
  localparam int CHK = 3;
  localparam int DB  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       rd_valid, rd_sel, rd_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic       reinit_pulse, mode_pal;
  logic [7:0] mode_word;

  int n_cmp = 0;
  int n_bad = 0;
  int stat_reads = 0;
  bit done = 0;
  bit stray = 0;
  logic [7:0] dev_reg = 8'h00;
  logic [7:0] dev_stat = 8'h02;
  bit exp_q[$];

  // bench model state
  logic [TW-1:0] now_m = '0, last_m = '0, ts_m = '0;
  bit armed_m = 0, pal_m = 0;
  logic [7:0] dev_m = 8'h00;

  always #2 clk = ~clk;

  vstd_monitor #(.TIME_W(TW), .CHECK_MS(CHK), .DEBOUNCE_MS(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cfg_mode(cfg_mode),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .reinit_pulse(reinit_pulse), .mode_pal(mode_pal), .mode_word(mode_word));

  function automatic logic [7:0] mw(input bit p);
    return p ? 8'h48 : 8'h08;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // transport/device model with alternating back-pressure
  initial begin
    bit bp;
    bit sel;
    bp = 1;
    rd_ready = 0; rsp_valid = 0; rsp_data = 8'h00;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        sel = rd_sel;
        if (bp) begin
          @(negedge clk);
          chk(rd_valid === 1'b1 && rd_sel === sel, "R2", "request held under back-pressure",
              {rd_valid, rd_sel}, {1'b1, sel});
        end
        bp = !bp;
        rd_ready = 1; @(negedge clk); rd_ready = 0;
        if (sel) stat_reads++;
        rsp_data = sel ? dev_stat : dev_reg;
        rsp_valid = 1; @(negedge clk); rsp_valid = 0;
      end else if (stray) begin
        stray = 0;
        rsp_data = 8'hFF; rsp_valid = 1; @(negedge clk); rsp_valid = 0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && reinit_pulse) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10", "unexpected reinit pulse", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(mode_pal == e, "R9", "mode_pal at pulse", mode_pal, e);
        chk(mode_word == mw(e), "R3", "mode_word at pulse", mode_word, mw(e));
      end
      dev_reg = mode_word;
    end
  end

  task automatic do_tick(input string tag);
    logic [TW-1:0] pn, d;
    int exp_reads;
    bit reinit, np, auto_m, los;
    pn = now_m;
    now_m = now_m + 1'b1;
    exp_reads = 0;
    reinit = 0;
    auto_m = (cfg_mode == 2'b00) || (cfg_mode == 2'b11);
    los = dev_stat[2];
    if (dev_m != mw(pal_m)) reinit = 1;
    else begin
      d = pn - last_m;
      if (auto_m && d > TW'(CHK)) begin
        last_m = pn;
        exp_reads++;
        if (los) armed_m = 0;
        else if (pal_m ? !dev_stat[0] : dev_stat[0]) begin
          if (armed_m) begin
            d = pn - ts_m;
            if (d > TW'(DB)) reinit = 1;
          end else begin
            armed_m = 1;
            ts_m = pn;
          end
        end
      end
    end
    if (reinit) begin
      if (cfg_mode == 2'b01) np = 1;
      else if (cfg_mode == 2'b10) np = 0;
      else begin
        exp_reads++;
        np = !los && !dev_stat[1] && dev_stat[0];
      end
      pal_m = np;
      armed_m = 0;
      dev_m = mw(np);
      exp_q.push_back(np);
    end
    stat_reads = 0;
    @(negedge clk) ms_tick = 1;
    @(negedge clk) ms_tick = 0;
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, tag, "expected reinit not seen", exp_q.size(), 0);
    exp_q.delete();
    chk(stat_reads == exp_reads, tag, "status reads in poll", stat_reads, exp_reads);
    chk(mode_pal == pal_m, tag, "selected mode after poll", mode_pal, pal_m);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) do_tick(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(reinit_pulse == 0, "R1", "pulse after reset", reinit_pulse, 0);
    chk(mode_pal == 0, "R1", "mode after reset", mode_pal, 0);
    chk(mode_word == 8'h08, "R1", "word after reset", mode_word, 8'h08);
    chk(rd_valid == 0, "R1", "no request after reset", rd_valid, 0);
    dev_stat = 8'h02; run(1, "R3");     // startup stall
    run(6, "R4");                        // periodic checks, NTSC steady
    dev_stat = 8'h01; run(16, "R8");     // debounce to PAL
    dev_stat = 8'h05; run(8, "R6");      // LOS with PAL bit
    dev_stat = 8'h22; run(5, "R5");      // NTSC plus busy bit arms
    dev_stat = 8'h04; run(5, "R6");      // LOS cancels
    dev_stat = 8'h00; run(16, "R7");     // loose NTSC, fallback on init
    stray = 1;
    repeat (20) @(negedge clk);
    chk(mode_pal == pal_m, "R2", "stray response ignored", mode_pal, pal_m);
    cfg_mode = 2'b01; run(10, "R4");     // forced, no status reads
    dev_reg = 8'hFF; dev_m = 8'hFF; run(1, "R3");
    cfg_mode = 2'b10;
    dev_reg = 8'h00; dev_m = 8'h00; run(1, "R9");
    cfg_mode = 2'b11; dev_stat = 8'h01; run(24, "R11");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule